// File: doc/BRIEF.md
# Way-Partitioned Lockable Victim Selector

This block decides which way of one cache set gets evicted when a requester misses and needs a place to put a refill. The caller presents the state bits of every way in the set: valid, dirty, locked and use. It also presents the identity of the requester, which is either one of several processor cores or the single shared requester that stands for all hardware engines. One clock later the block returns the chosen way. It also says whether any way could be taken at all, and whether the chosen line must be written back before it is reused.

Each requester owns a partition mask held in a register inside the block. A cleared bit lets that requester evict from the matching way. A set bit keeps it out of that way. The masks restrict eviction only. Hit lookups happen outside this block and may match any way. Locked lines are never offered for eviction. Among the ways that remain, the pick prefers an empty way, then a way whose use bit is clear, then simply the lowest-numbered way. The block also derives the set index of the request address, assuming 128-byte lines.

Top module: `wpv_victim_sel`

## Requirements
- R1: After reset `vic_valid` is 0 and every partition mask is zero, so every requester may evict from every way.
- R2: A request sampled with `req_valid` high produces `vic_valid` high on the following cycle, with `vic_found`, `vic_way` and `vic_wb` for that request. `vic_valid` is low in every cycle that does not follow a request.
- R3: Requester ids 0 to NUM_CORES-1 select the core masks and id NUM_CORES selects the shared hardware mask. Mask bit k equal to 1 keeps that requester from evicting way k, and bit k equal to 0 allows it.
- R4: A mask write whose data is all ones is rejected, and the mask keeps its previous value.
- R5: A legal mask write (`mask_wr_en` high) takes effect for requests sampled from the next cycle onward. A request sampled in the same cycle as the write still uses the old mask. A write whose selector is above NUM_CORES changes no mask.
- R6: A way whose locked bit is 1 is never returned as the victim.
- R7: Candidates are the ways that are both allowed and unlocked. If any candidate has valid 0, the lowest-numbered such way is chosen.
- R8: Otherwise, if any candidate has its use bit 0, the lowest-numbered such way is chosen.
- R9: Otherwise the lowest-numbered candidate is chosen.
- R10: With no candidate, `vic_found`, `vic_way` and `vic_wb` are all 0.
- R11: `vic_wb` is 1 exactly when a victim is found and that way's valid and dirty bits are both 1.
- R12: `set_idx` equals `req_addr` shifted right by 7 and masked to NUM_SETS-1. It is combinational.
- R13: A request whose id is above NUM_CORES finds no victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr_en | input | 1 | Partition mask write strobe |
| mask_wr_sel | input | RID_W (3) | Requester whose mask is written |
| mask_wr_data | input | NUM_WAYS (8) | New mask, 1 blocks eviction from a way |
| req_valid | input | 1 | Victim request strobe |
| req_id | input | RID_W (3) | Requesting core, or NUM_CORES for the hardware requester |
| req_addr | input | ADDR_W (32) | Physical address of the missing line |
| way_valid | input | NUM_WAYS (8) | Valid bit per way |
| way_dirty | input | NUM_WAYS (8) | Dirty bit per way |
| way_locked | input | NUM_WAYS (8) | Locked bit per way |
| way_use | input | NUM_WAYS (8) | Use bit per way |
| set_idx | output | SET_W (10) | Set index of req_addr |
| vic_valid | output | 1 | Result strobe, one cycle after a request |
| vic_found | output | 1 | A victim way was found |
| vic_way | output | WAY_W (3) | Chosen way |
| vic_wb | output | 1 | Chosen line is valid and dirty |

## Verification
Two situations are hard to reach from the ports. One is a set in which every way is either locked or blocked for the asking requester. The other is the race between a mask write and a request in the same cycle. The stimulus table first loads distinct masks for several requesters, with one core allowed into a single way. It then walks state patterns in which locks, invalid lines and clear use bits sit on both sides of the mask boundary, so each preference level wins or loses on the mask alone. Directed steps then issue a mask write together with a request, and follow it with a second request to see the cut-over. They also try an all-ones write and a write to a missing requester, and read the effect back through later picks.

// File: rtl/wpv_pkg.sv
package wpv_pkg;

    localparam int LINE_SHIFT_DEF = 7;

    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_EMPTY   = 2'd1,
        PICK_UNUSED  = 2'd2,
        PICK_LOWEST  = 2'd3
    } pick_kind_e;

endpackage

// File: rtl/wpv_mask_bank.sv
module wpv_mask_bank
    import wpv_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int NUM_REQ  = 5,
    parameter int RID_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [RID_W-1:0]    wr_sel,
    input  logic [NUM_WAYS-1:0] wr_data,
    input  logic [RID_W-1:0]    rd_id,
    output logic [NUM_WAYS-1:0] rd_mask,
    output logic                rd_ok
);

    logic [NUM_WAYS-1:0] mask_q [NUM_REQ];
    logic                wr_legal;

    assign wr_legal = wr_en && !(&wr_data);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= '0;
            end else if (wr_legal && (wr_sel == RID_W'(g))) begin
                mask_q[g] <= wr_data;
            end
        end

        // R4
        mask_legal_chk: assert property (@(posedge clk) disable iff (rst)
            !(&mask_q[g]));

        // R4
        mask_reject_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel == RID_W'(g)) && (&wr_data)) |=> $stable(mask_q[g]));
    end

    always_comb begin
        rd_mask = '1;
        rd_ok   = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (rd_id == RID_W'(i)) begin
                rd_mask = mask_q[i];
                rd_ok   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wpv_way_pick.sv
module wpv_way_pick
    import wpv_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int WAY_W    = 3
) (
    input  logic                req_ok,
    input  logic [NUM_WAYS-1:0] block_mask,
    input  logic [NUM_WAYS-1:0] st_valid,
    input  logic [NUM_WAYS-1:0] st_dirty,
    input  logic [NUM_WAYS-1:0] st_locked,
    input  logic [NUM_WAYS-1:0] st_use,
    output logic                found,
    output logic [WAY_W-1:0]    way,
    output logic                wb,
    output pick_kind_e          kind
);

    logic [NUM_WAYS-1:0] cand;
    logic [NUM_WAYS-1:0] cand_empty;
    logic [NUM_WAYS-1:0] cand_unused;

    function automatic logic [WAY_W-1:0] lowest_set(input logic [NUM_WAYS-1:0] vec);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (vec[i]) r = WAY_W'(i);
        end
        return r;
    endfunction

    assign cand        = ~block_mask & ~st_locked & {NUM_WAYS{req_ok}};
    assign cand_empty  = cand & ~st_valid;
    assign cand_unused = cand & ~st_use;

    always_comb begin
        kind = PICK_NONE;
        way  = '0;
        if (|cand_empty) begin
            kind = PICK_EMPTY;
            way  = lowest_set(cand_empty);
        end else if (|cand_unused) begin
            kind = PICK_UNUSED;
            way  = lowest_set(cand_unused);
        end else if (|cand) begin
            kind = PICK_LOWEST;
            way  = lowest_set(cand);
        end
        found = (kind != PICK_NONE);
        wb    = found && st_valid[way] && st_dirty[way];
    end

endmodule

// File: rtl/wpv_victim_sel.sv
module wpv_victim_sel
    import wpv_pkg::*;
#(
    parameter int NUM_WAYS   = 8,
    parameter int NUM_CORES  = 4,
    parameter int NUM_SETS   = 1024,
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = LINE_SHIFT_DEF,
    localparam int NUM_REQ   = NUM_CORES + 1,
    localparam int RID_W     = $clog2(NUM_REQ + 1),
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int SET_W     = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mask_wr_en,
    input  logic [RID_W-1:0]    mask_wr_sel,
    input  logic [NUM_WAYS-1:0] mask_wr_data,
    input  logic                req_valid,
    input  logic [RID_W-1:0]    req_id,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_dirty,
    input  logic [NUM_WAYS-1:0] way_locked,
    input  logic [NUM_WAYS-1:0] way_use,
    output logic [SET_W-1:0]    set_idx,
    output logic                vic_valid,
    output logic                vic_found,
    output logic [WAY_W-1:0]    vic_way,
    output logic                vic_wb
);

    logic [NUM_WAYS-1:0] sel_mask;
    logic                sel_ok;
    logic                pk_found;
    logic [WAY_W-1:0]    pk_way;
    logic                pk_wb;
    pick_kind_e          pk_kind;

    assign set_idx = req_addr[LINE_SHIFT +: SET_W];

    wpv_mask_bank #(
        .NUM_WAYS (NUM_WAYS),
        .NUM_REQ  (NUM_REQ),
        .RID_W    (RID_W)
    ) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en),
        .wr_sel  (mask_wr_sel),
        .wr_data (mask_wr_data),
        .rd_id   (req_id),
        .rd_mask (sel_mask),
        .rd_ok   (sel_ok)
    );

    wpv_way_pick #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_pick (
        .req_ok     (sel_ok),
        .block_mask (sel_mask),
        .st_valid   (way_valid),
        .st_dirty   (way_dirty),
        .st_locked  (way_locked),
        .st_use     (way_use),
        .found      (pk_found),
        .way        (pk_way),
        .wb         (pk_wb),
        .kind       (pk_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vic_valid <= 1'b0;
            vic_found <= 1'b0;
            vic_way   <= '0;
            vic_wb    <= 1'b0;
        end else begin
            vic_valid <= req_valid;
            if (req_valid) begin
                vic_found <= pk_found;
                vic_way   <= pk_way;
                vic_wb    <= pk_wb;
            end
        end
    end

    // R2
    resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> vic_valid);

    // R6
    no_locked_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pk_found) |=>
            ((($past(way_locked) >> vic_way) & NUM_WAYS'(1)) == '0));

    // R3
    mask_respected_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pk_found) |=>
            ((($past(sel_mask) >> vic_way) & NUM_WAYS'(1)) == '0));

    // R10
    wb_needs_found_chk: assert property (@(posedge clk) disable iff (rst)
        vic_wb |-> vic_found);

    // R13
    bad_id_none_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel_ok) |=> !vic_found);

endmodule

// File: tb/wpv_victim_sel_tb.sv
`timescale 1ns/1ps
module wpv_victim_sel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        mask_wr_en;
    logic [2:0]  mask_wr_sel;
    logic [7:0]  mask_wr_data;
    logic        req_valid;
    logic [2:0]  req_id;
    logic [31:0] req_addr;
    logic [7:0]  way_valid, way_dirty, way_locked, way_use;
    logic [9:0]  set_idx;
    logic        vic_valid, vic_found, vic_wb;
    logic [2:0]  vic_way;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wpv_victim_sel u_dut (
        .clk(clk), .rst(rst),
        .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
        .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
        .way_valid(way_valid), .way_dirty(way_dirty), .way_locked(way_locked), .way_use(way_use),
        .set_idx(set_idx), .vic_valid(vic_valid), .vic_found(vic_found),
        .vic_way(vic_way), .vic_wb(vic_wb)
    );

    typedef struct packed {
        logic [2:0] id;
        logic [7:0] v;
        logic [7:0] d;
        logic [7:0] l;
        logic [7:0] u;
        logic       f;
        logic [2:0] w;
        logic       wb;
    } vec_t;

    // masks in force: core0 00, core1 0F, core2 FE, core3 00, hw(id 4) F0
    localparam vec_t VECS [12] = '{
        '{3'd0, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b1, 3'd0, 1'b0}, // R9
        '{3'd0, 8'hF7, 8'hFF, 8'h00, 8'hFF, 1'b1, 3'd3, 1'b0}, // R7
        '{3'd0, 8'hFF, 8'hFF, 8'h00, 8'hEF, 1'b1, 3'd4, 1'b1}, // R8 R11
        '{3'd0, 8'hFF, 8'h00, 8'h01, 8'hFF, 1'b1, 3'd1, 1'b0}, // R6
        '{3'd1, 8'hFE, 8'hFF, 8'h00, 8'hFF, 1'b1, 3'd4, 1'b1}, // R3
        '{3'd1, 8'hFF, 8'h00, 8'hF0, 8'hFF, 1'b0, 3'd0, 1'b0}, // R10
        '{3'd2, 8'hFF, 8'h01, 8'h00, 8'hFF, 1'b1, 3'd0, 1'b1}, // R3 R11
        '{3'd4, 8'hFF, 8'h00, 8'h01, 8'hF3, 1'b1, 3'd2, 1'b0}, // R8 R6
        '{3'd5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0}, // R13
        '{3'd3, 8'h7F, 8'h80, 8'h00, 8'h00, 1'b1, 3'd7, 1'b0}, // R7 R11
        '{3'd0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 3'd0, 1'b0}, // R6 R10
        '{3'd4, 8'hBF, 8'h00, 8'h00, 8'hFF, 1'b1, 3'd0, 1'b0}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [2:0] sel, input logic [7:0] data);
        mask_wr_en   = 1'b1;
        mask_wr_sel  = sel;
        mask_wr_data = data;
        @(negedge clk);
        mask_wr_en   = 1'b0;
    endtask

    task automatic issue(input logic [2:0] id, input logic [7:0] v, input logic [7:0] d,
                         input logic [7:0] l, input logic [7:0] u);
        req_valid  = 1'b1;
        req_id     = id;
        way_valid  = v;
        way_dirty  = d;
        way_locked = l;
        way_use    = u;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic f, input logic [2:0] w, input logic wb);
        check({req, " valid"}, 32'(vic_valid), 32'd1);
        check({req, " found"}, 32'(vic_found), 32'(f));
        check({req, " way"},   32'(vic_way),   32'(w));
        check({req, " wb"},    32'(vic_wb),    32'(wb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mask_wr_en = 1'b0; mask_wr_sel = '0; mask_wr_data = '0;
        req_valid = 1'b0; req_id = '0; req_addr = '0;
        way_valid = '0; way_dirty = '0; way_locked = '0; way_use = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, all masks zero -> core2 and hw may take way 7
        check("R1 vic_valid", 32'(vic_valid), 32'd0);
        issue(3'd2, 8'h7F, 8'h00, 8'h00, 8'hFF);
        expect_resp("R1 core2", 1'b1, 3'd7, 1'b0);
        issue(3'd4, 8'h7F, 8'h00, 8'h00, 8'hFF);
        expect_resp("R1 hw", 1'b1, 3'd7, 1'b0);
        @(negedge clk);
        check("R2 idle vic_valid", 32'(vic_valid), 32'd0);

        // R12: set index
        req_addr = 32'h0000_3F80; #1;
        check("R12 set_idx a", 32'(set_idx), 32'h7F);
        req_addr = 32'hFFFF_FF80; #1;
        check("R12 set_idx b", 32'(set_idx), 32'h3FF);
        req_addr = 32'h0001_207F; #1;
        check("R12 set_idx c", 32'(set_idx), 32'h240);

        // load masks
        wr_mask(3'd1, 8'h0F);
        wr_mask(3'd2, 8'hFE);
        wr_mask(3'd4, 8'hF0);

        for (int i = 0; i < 12; i++) begin
            issue(VECS[i].id, VECS[i].v, VECS[i].d, VECS[i].l, VECS[i].u);
            expect_resp($sformatf("R7-R11 table vec %0d", i), VECS[i].f, VECS[i].w, VECS[i].wb);
        end

        // R4: all-ones write rejected, core1 keeps 0F
        wr_mask(3'd1, 8'hFF);
        issue(3'd1, 8'hFF, 8'h00, 8'h00, 8'hFF);
        expect_resp("R4 reject", 1'b1, 3'd4, 1'b0);

        // R5: write to missing requester 6 changes no mask
        wr_mask(3'd6, 8'h01);
        issue(3'd0, 8'hFF, 8'h00, 8'h00, 8'hFF);
        expect_resp("R5 bad sel core0", 1'b1, 3'd0, 1'b0);
        issue(3'd3, 8'hFF, 8'h00, 8'h00, 8'hFF);
        expect_resp("R5 bad sel core3", 1'b1, 3'd0, 1'b0);

        // R5: write and request in same cycle use old mask, next uses new
        mask_wr_en = 1'b1; mask_wr_sel = 3'd0; mask_wr_data = 8'h01;
        issue(3'd0, 8'hFF, 8'h00, 8'h00, 8'hFF);
        mask_wr_en = 1'b0;
        expect_resp("R5 same cycle", 1'b1, 3'd0, 1'b0);
        issue(3'd0, 8'hFF, 8'h00, 8'h00, 8'hFF);
        expect_resp("R5 next cycle", 1'b1, 3'd1, 1'b0);

        // R2: back-to-back requests then idle
        issue(3'd4, 8'hFF, 8'hFF, 8'h00, 8'hFD);
        expect_resp("R2 b2b first", 1'b1, 3'd1, 1'b1);
        issue(3'd2, 8'hFF, 8'h00, 8'h00, 8'hFF);
        expect_resp("R2 b2b second", 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check("R2 after pulse", 32'(vic_valid), 32'd0);

        // R1: reset restores open masks
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rst vic_valid", 32'(vic_valid), 32'd0);
        issue(3'd2, 8'hFF, 8'h00, 8'h00, 8'hEF);
        expect_resp("R1 core2 after rst", 1'b1, 3'd4, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule